// File: doc/BRIEF.md
# Drift-Compensated Seconds Divider

This block turns a nominally 32.768 kHz input clock into a one-cycle pulse once per second. It can also correct a crystal that runs slightly fast or slow. A signed trim value tells it how many input cycles a 15-second frame must gain or lose. When trimming is switched on, the block lengthens or shortens a chosen number of seconds at the start of each frame by one or two cycles. The rest of the frame uses a ratio one step closer to nominal. Each frame therefore lasts exactly `FRAME_SECS × NOM_DIV + E` input cycles.

Every frame follows the same schedule. Individual seconds within a frame may differ in length. The trim value and the enable are taken in only at frame boundaries, so a single frame never mixes two settings. The nominal ratio and the frame length are parameters. The defaults are 32768 and 15, and a bench may use a small nominal ratio.

Top module: `rtc_comp_divider`

## Requirements
- R1: While reset is asserted, `sec_tick_o` is low. The reset release passes through a two-stage synchronizer, so the first tick arrives on the rising edge NOM_DIV+1 after the release. The first frame after reset always runs at the nominal ratio, whatever the inputs are.
- R2: `sec_tick_o` is high for exactly one clock cycle per second. The spacing from one tick to the next equals the divide ratio chosen for that second.
- R3: While the latched enable is 0, or the latched trim value is 0, every second lasts NOM_DIV cycles.
- R4: For a trim value E with −FRAME_SECS ≤ E ≤ −1, seconds 0 to |E|−1 of the frame last NOM_DIV−1 cycles. All later seconds in the frame last NOM_DIV cycles.
- R5: For −2·FRAME_SECS ≤ E < −FRAME_SECS, the first |E|−FRAME_SECS seconds last NOM_DIV−2 cycles. All later seconds last NOM_DIV−1 cycles.
- R6: For 1 ≤ E ≤ FRAME_SECS, the first E seconds last NOM_DIV+1 cycles. All later seconds last NOM_DIV cycles.
- R7: For FRAME_SECS < E ≤ 2·FRAME_SECS, the first E−FRAME_SECS seconds last NOM_DIV+2 cycles. All later seconds last NOM_DIV+1 cycles.
- R8: Every frame after the first lasts exactly FRAME_SECS·NOM_DIV + E cycles, where E is the latched, clamped trim value, or 0 when trimming is off.
- R9: The enable and the trim value are sampled only on the clock edge that ends the last second of a frame, and they govern the whole of the next frame. Changes made at any other time have no effect on the current frame or on the next frame.
- R10: `err_i` is a two's-complement value EW bits wide. A value above +2·FRAME_SECS acts as +2·FRAME_SECS, and a value below −2·FRAME_SECS acts as −2·FRAME_SECS.
- R11: The position of a second within its frame counts 0 to FRAME_SECS−1 and returns to 0 after the last second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Nominal 32.768 kHz input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| comp_en_i | input | 1 | Turns drift trimming on for the next frame |
| err_i | input | EW | Signed cycle error per frame (two's complement) |
| sec_tick_o | output | 1 | One-cycle pulse at the end of every second |

## Verification
The bench covers the edges of each band: |E| of 1, 15, 16 and 30. At these values an off-by-one in the band selection gives a frame that is one or two cycles wrong, or a second scheduled on the wrong side of the split point. It also drives trim values of +31 and −32, which lie outside the legal range. An unclamped design would stretch or shrink the frame past its limit there. In one frame the bench changes the settings in the middle. A design that samples its inputs continuously would mix two schedules in that frame or in the next. The bench also checks the length of the first second after reset, to confirm that the reset synchronizer delay is counted. It also confirms that the inputs present during reset are ignored for the first frame.

// File: rtl/rtc_comp_pkg.sv
package rtc_comp_pkg;

  // Which pair of divide ratios a frame uses.
  typedef enum logic [1:0] {
    BAND_NONE   = 2'd0,  // nominal ratio throughout
    BAND_FINE   = 2'd1,  // steps of one cycle: +-1 then 0
    BAND_COARSE = 2'd2   // steps of two then one cycle: +-2 then +-1
  } band_e;

  localparam int unsigned CNT_A_W = 8;

  // Schedule of one frame, held stable for the whole frame.
  typedef struct packed {
    band_e               band;
    logic                shorten;  // 1: trim value negative, seconds get shorter
    logic [CNT_A_W-1:0]  cnt_a;    // number of leading seconds using the larger step
  } sched_t;

endpackage

// File: rtl/rtc_comp_latch.sv
module rtc_comp_latch
  import rtc_comp_pkg::*;
#(
  parameter int unsigned FRAME_SECS = 15,
  parameter int unsigned EW         = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_end_i,
  input  logic                 comp_en_i,
  input  logic signed [EW-1:0] err_i,
  output sched_t               sched_q_o,
  output sched_t               sched_nxt_o
);

  localparam int unsigned    MAG_W   = EW + 1;
  localparam logic [MAG_W-1:0] MAG_MAX = MAG_W'(2 * FRAME_SECS);
  localparam logic [MAG_W-1:0] MAG_FS  = MAG_W'(FRAME_SECS);

  logic signed [MAG_W-1:0] err_ext;
  logic [MAG_W-1:0]        mag_raw;
  logic [MAG_W-1:0]        mag;
  sched_t                  sched_new;
  sched_t                  sched_d;
  sched_t                  sched_q;

  // Magnitude with saturation to twice the frame length.
  always_comb begin
    err_ext = {err_i[EW-1], err_i};
    mag_raw = err_ext[MAG_W-1] ? $unsigned(-err_ext) : $unsigned(err_ext);
    mag     = (mag_raw > MAG_MAX) ? MAG_MAX : mag_raw;
  end

  // Translate the trim value into a frame schedule.
  always_comb begin
    sched_new = '0;
    if (comp_en_i && (mag != '0)) begin
      sched_new.shorten = err_ext[MAG_W-1];
      if (mag <= MAG_FS) begin
        sched_new.band  = BAND_FINE;
        sched_new.cnt_a = CNT_A_W'(mag);
      end else begin
        sched_new.band  = BAND_COARSE;
        sched_new.cnt_a = CNT_A_W'(mag - MAG_FS);
      end
    end
  end

  // Settings move only at a frame boundary.
  always_comb begin
    sched_d = sched_q;
    if (frame_end_i) begin
      sched_d = sched_new;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sched_q <= '0;
    end else begin
      sched_q <= sched_d;
    end
  end

  assign sched_q_o   = sched_q;
  assign sched_nxt_o = sched_d;

endmodule

// File: rtl/rtc_frame_pos.sv
module rtc_frame_pos #(
  parameter int unsigned FRAME_SECS = 15,
  parameter int unsigned SW         = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [SW-1:0] sec_q_o,
  output logic [SW-1:0] sec_nxt_o,
  output logic          frame_end_o
);

  localparam logic [SW-1:0] SEC_LAST = SW'(FRAME_SECS - 1);

  logic [SW-1:0] sec_q;
  logic [SW-1:0] sec_d;

  assign frame_end_o = tick_i && (sec_q == SEC_LAST);

  always_comb begin
    sec_d = sec_q;
    if (frame_end_o) begin
      sec_d = '0;
    end else if (tick_i) begin
      sec_d = sec_q + SW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
    end else begin
      sec_q <= sec_d;
    end
  end

  assign sec_q_o   = sec_q;
  assign sec_nxt_o = sec_d;

endmodule

// File: rtl/rtc_period_cnt.sv
module rtc_period_cnt #(
  parameter int unsigned NOM_DIV = 32768,
  parameter int unsigned CW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] div_next_i,
  output logic          tick_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // Down counter: terminal count at zero, then reload with the next ratio.
  assign tick_o = (cnt_q == '0);

  always_comb begin
    if (tick_o) begin
      cnt_d = div_next_i - CW'(1);
    end else begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(NOM_DIV - 1);
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rtc_comp_divider.sv
module rtc_comp_divider
  import rtc_comp_pkg::*;
#(
  parameter int unsigned NOM_DIV    = 32768,
  parameter int unsigned FRAME_SECS = 15,
  parameter int unsigned EW         = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 comp_en_i,
  input  logic signed [EW-1:0] err_i,
  output logic                 sec_tick_o
);

  localparam int unsigned CW = $clog2(NOM_DIV + 3);
  localparam int unsigned SW = (FRAME_SECS > 1) ? $clog2(FRAME_SECS) : 1;

  logic          rst_meta_q;
  logic          rst_sync_q;
  logic          tick;
  logic          frame_end;
  logic [SW-1:0] sec_q;
  logic [SW-1:0] sec_nxt;
  sched_t        sched_q;
  sched_t        sched_nxt;
  logic          in_a;
  logic [1:0]    step;
  logic [CW-1:0] div_next;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rtc_period_cnt #(
    .NOM_DIV (NOM_DIV),
    .CW      (CW)
  ) i_period (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .div_next_i (div_next),
    .tick_o     (tick)
  );

  rtc_frame_pos #(
    .FRAME_SECS (FRAME_SECS),
    .SW         (SW)
  ) i_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .tick_i      (tick),
    .sec_q_o     (sec_q),
    .sec_nxt_o   (sec_nxt),
    .frame_end_o (frame_end)
  );

  rtc_comp_latch #(
    .FRAME_SECS (FRAME_SECS),
    .EW         (EW)
  ) i_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .frame_end_i (frame_end),
    .comp_en_i   (comp_en_i),
    .err_i       (err_i),
    .sched_q_o   (sched_q),
    .sched_nxt_o (sched_nxt)
  );

  // Ratio for the second about to start: leading seconds take the larger step.
  always_comb begin
    in_a = CNT_A_W'(sec_nxt) < sched_nxt.cnt_a;
    unique case (sched_nxt.band)
      BAND_FINE:   step = in_a ? 2'd1 : 2'd0;
      BAND_COARSE: step = in_a ? 2'd2 : 2'd1;
      default:     step = 2'd0;
    endcase
    if (sched_nxt.shorten) begin
      div_next = CW'(NOM_DIV) - CW'(step);
    end else begin
      div_next = CW'(NOM_DIV) + CW'(step);
    end
  end

  assign sec_tick_o = tick;

endmodule

// File: rtl/rtc_comp_divider_chk.sv
module rtc_comp_divider_chk
  import rtc_comp_pkg::*;
#(
  parameter int unsigned NOM_DIV    = 32768,
  parameter int unsigned FRAME_SECS = 15,
  parameter int unsigned SW         = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          frame_end_i,
  input logic [SW-1:0] sec_i,
  input sched_t        sched_i
);

  logic [31:0] frame_cyc_q;
  logic        seen_q;
  int          trim;
  int          exp_len;

  // Cycles since the previous frame boundary.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_cyc_q <= '0;
      seen_q      <= 1'b0;
    end else if (frame_end_i) begin
      frame_cyc_q <= '0;
      seen_q      <= 1'b1;
    end else begin
      frame_cyc_q <= frame_cyc_q + 32'd1;
    end
  end

  always_comb begin
    case (sched_i.band)
      BAND_FINE:   trim = int'(sched_i.cnt_a);
      BAND_COARSE: trim = int'(sched_i.cnt_a) + int'(FRAME_SECS);
      default:     trim = 0;
    endcase
    if (sched_i.shorten) begin
      trim = -trim;
    end
    exp_len = int'(FRAME_SECS * NOM_DIV) + trim;
  end

  a_r2_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  a_r8_frame_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && seen_q) |-> (int'(frame_cyc_q) + 1 == exp_len));

  a_r9_sched_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(sched_i));

  a_r10_trim_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sched_i.band != BAND_NONE) |-> (sched_i.cnt_a <= CNT_A_W'(FRAME_SECS) && sched_i.cnt_a != '0));

  a_r11_sec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (sec_i < SW'(FRAME_SECS)));

  a_r11_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> (sec_i == '0));

endmodule

bind rtc_comp_divider rtc_comp_divider_chk #(
  .NOM_DIV    (NOM_DIV),
  .FRAME_SECS (FRAME_SECS),
  .SW         (SW)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_q),
  .tick_i      (tick),
  .frame_end_i (frame_end),
  .sec_i       (sec_q),
  .sched_i     (sched_q)
);

// File: tb/test_rtc_comp_divider.sv
module test_rtc_comp_divider;

  localparam int NOM = 64;
  localparam int FS  = 15;
  localparam int EW  = 6;
  localparam int WD  = 150000;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 en = 1'b0;
  logic signed [EW-1:0] err = '0;
  logic                 tick;

  always #10 clk = ~clk;  // 50 MHz

  rtc_comp_divider #(
    .NOM_DIV    (NOM),
    .FRAME_SECS (FS),
    .EW         (EW)
  ) i_rtc_comp_divider (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .comp_en_i  (en),
    .err_i      (err),
    .sec_tick_o (tick)
  );

  int    errors = 0;
  int    checks = 0;
  int    exp_q[$];
  string tag_q[$];
  int    sum_q[$];
  int    prev_en;
  int    prev_e;
  string prev_tag;

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int clamp_e(int e);
    if (e > 2 * FS) return 2 * FS;
    if (e < -2 * FS) return -2 * FS;
    return e;
  endfunction

  // Second length from the band rules (R3..R7).
  function automatic int exp_div(int en_v, int e, int s);
    int m;
    int sg;
    if (en_v == 0 || e == 0) return NOM;
    m  = (e < 0) ? -e : e;
    sg = (e < 0) ? -1 : 1;
    if (m <= FS) return (s < m) ? NOM + sg : NOM;
    return (s < m - FS) ? NOM + 2 * sg : NOM + sg;
  endfunction

  function automatic string tag_of(int en_v, int raw);
    if (en_v == 0 || raw == 0) return "R3";
    if (raw > 2 * FS || raw < -2 * FS) return "R10";
    if (raw < -FS) return "R5";
    if (raw < 0) return "R4";
    if (raw <= FS) return "R6";
    return "R7";
  endfunction

  task automatic push_frame();
    int sum = 0;
    for (int s = 0; s < FS; s++) begin
      exp_q.push_back(exp_div(prev_en, prev_e, s));
      tag_q.push_back(prev_tag);
      sum += exp_div(prev_en, prev_e, s);
    end
    sum_q.push_back(sum);
  endtask

  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick);
    end
  endtask

  // Inputs driven here govern the frame after the one being checked.
  task automatic run_frame(int en_v, int e_v);
    en  = (en_v != 0);
    err = EW'(e_v);
    push_frame();
    wait_ticks(FS);
    @(negedge clk);
    prev_en  = en_v;
    prev_e   = clamp_e(e_v);
    prev_tag = tag_of(en_v, e_v);
  endtask

  // Change settings mid-frame: only the value present at the boundary counts (R9).
  task automatic run_swap(int en1, int e1, int en2, int e2);
    en  = (en1 != 0);
    err = EW'(e1);
    push_frame();
    wait_ticks(7);
    en  = (en2 != 0);
    err = EW'(e2);
    wait_ticks(FS - 7);
    @(negedge clk);
    prev_en  = en2;
    prev_e   = clamp_e(e2);
    prev_tag = "R9";
  endtask

  // Monitor: measure tick spacing and compare against the queue.
  int cyc = 0;
  int n_items = 0;
  int acc = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0;
    end else begin
      cyc++;
      if (tick) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected tick", cyc, -1);
        end else begin
          check(tag_q.pop_front(), cyc, exp_q.pop_front());
        end
        acc += cyc;
        n_items++;
        if (n_items % FS == 0) begin
          if (n_items > FS && sum_q.size() > 0) check("R8 frame length", acc, sum_q.pop_front());
          acc = 0;
        end
        cyc = 0;
      end
    end
  end

  initial begin
    fork
      begin
        // Inputs during reset must not affect the first frame (R1).
        en  = 1'b1;
        err = EW'(7);
        repeat (4) @(negedge clk);
        check("R1 tick low in reset", int'(tick), 0);
        #5 rst_n = 1'b1;
        exp_q.push_back(NOM + 1);
        tag_q.push_back("R1");
        for (int s = 1; s < FS; s++) begin
          exp_q.push_back(NOM);
          tag_q.push_back("R1");
        end
        wait_ticks(FS);
        @(negedge clk);
        prev_en = 1; prev_e = 7; prev_tag = "R6";
        run_frame(1, 0);
        run_frame(1, 5);
        run_frame(1, -5);
        run_frame(1, 15);
        run_frame(1, -15);
        run_frame(1, 16);
        run_frame(1, -16);
        run_frame(1, 30);
        run_frame(1, -30);
        run_frame(1, 31);
        run_frame(1, -32);
        run_frame(0, 20);
        run_swap(1, -9, 1, 1);
        run_frame(1, -1);
        run_frame(0, 0);
        repeat (4) @(negedge clk);
        check("R2 all seconds seen", exp_q.size(), 0);
      end
      begin
        repeat (WD) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule